// File: doc/BRIEF.md
# Sleep-Mode and Reset Qualification Controller

This block sits beside an 8-bit microcontroller core. It governs the core's two power-saving states: a light sleep, in which only the processor clock is gated, and a deep sleep, in which the oscillator is asked to stop. Software enters either state by writing a pair of mode-request bits. The block decides how each state ends. Light sleep ends on any enabled pending interrupt or on a hardware reset. Deep sleep ends on a hardware reset and on nothing else.

A free-running divider splits the oscillator into machine cycles. The raw reset pin is synchronised and then sampled once per machine cycle. The internal reset only rises once the pin has been seen high on consecutive machine-cycle samples. Sometimes the reset pin is what ends light sleep. In that case the processor clock restarts at the first high sample, and internal RAM writes are blocked until the qualified reset takes over. While the chip sleeps, the block also forces the address-latch strobe, the program-store strobe and the two address ports into a defined state. That state depends on whether code is fetched from internal or external program memory.

Top module: `lpm_rst_ctrl`

## Requirements
- R1: `int_rst` rises only after the synchronised reset pin has been sampled high on two consecutive machine-cycle ticks. A pin pulse that covers only one tick leaves `int_rst` low.
- R2: Once asserted, `int_rst` falls at the first tick on which the synchronised pin is sampled low.
- R3: `mcyc_tick` is high for exactly one clock in every 12 clocks.
- R4: A mode write (`mode_we`=1 while running) with `mode_pd_set`=1 enters deep sleep. With only `mode_idle_set`=1 it enters light sleep. When both bits are 1, deep sleep is chosen.
- R5: In light sleep, `cpu_clk_en`=0, `per_clk_en`=1, `osc_stop`=0 and `mode_idle`=1.
- R6: In light sleep, `irq_pend`=1 returns the block to running on the next clock edge: `cpu_clk_en` becomes 1 and `mode_idle` becomes 0.
- R7: In deep sleep, `cpu_clk_en`=0, `per_clk_en`=0, `osc_stop`=1 and `mode_pd`=1. `irq_pend` has no effect. Only `int_rst` ends deep sleep, and it clears `mode_pd`.
- R8: In light sleep, the first tick that samples the pin high restarts the processor clock and sets `ram_wr_block`=1, while `mode_idle` stays 1. The block then returns to running, with `mode_idle`=0 and `ram_wr_block`=0, in either of two cases: `int_rst` asserts, or a later tick samples the pin low.
- R9: While asleep, `pin_hold`=1. In light sleep, `ale_lvl`=1 and `psen_lvl`=1. In deep sleep, both are 0. While running, `pin_hold`=0.
- R10: With `ext_code`=1, `p0_float`=1 in both sleep states, and `p2_addr`=1 (port 2 shows the address byte) in light sleep only. With `ext_code`=0, both are 0 and every port keeps its latched data.
- R11: A mode write is ignored when it arrives while asleep, during a reset wake-up, or while `int_rst` is high.
- R12: In light sleep, a tick that samples the pin high takes precedence over `irq_pend` arriving in the same clock. The block enters the reset wake-up of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| mode_we | input | 1 | Mode-register write strobe |
| mode_idle_set | input | 1 | Light-sleep request bit of the write |
| mode_pd_set | input | 1 | Deep-sleep request bit of the write |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_code | input | 1 | 1 when code runs from external program memory |
| mcyc_tick | output | 1 | One-clock machine-cycle strobe |
| int_rst | output | 1 | Qualified internal reset |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_stop | output | 1 | Request to stop the oscillator |
| ram_wr_block | output | 1 | Blocks internal RAM writes during reset wake-up |
| mode_idle | output | 1 | Light-sleep mode bit |
| mode_pd | output | 1 | Deep-sleep mode bit |
| pin_hold | output | 1 | Pin overrides active |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-store strobe level |
| p0_float | output | 1 | Port 0 released to high impedance |
| p2_addr | output | 1 | Port 2 shows the address byte rather than its latch |

## Verification
Two exits from light sleep can fall in the same clock: the interrupt exit, and the reset wake-up triggered by a machine-cycle sample of the reset pin. The bench aligns to `mcyc_tick`. It raises the pin early enough to pass the synchroniser just before a tick, and raises `irq_pend` so that it is first seen on that same tick edge. The result is judged on the next clock. `ram_wr_block` must be 1 with `mode_idle` still 1. An interrupt win would instead show a running core with both at 0.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2,
      PM_WAKE = 2'd3
   } pm_state_t;
endpackage

// File: rtl/lpm_cycle_tick.sv
module lpm_cycle_tick #(
   parameter int CYC_LEN = 12
) (
   input  logic clk,
   input  logic por_n,
   output logic tick
);
   localparam int CW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);

   generate
      if (CYC_LEN < 2) begin : g_bad_len
         $error("lpm_cycle_tick: CYC_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   // R3: the strobe never lasts two clocks
   p_tick_single_r3: assert property (@(posedge clk) disable iff (!por_n)
      tick |=> !tick);
endmodule

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYC    = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick,
   input  logic rst_pin,
   output logic rst_seen,
   output logic rst_drop,
   output logic int_rst
);
   localparam int HW = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);
   localparam logic [HW-1:0] HOLD_PRE = HW'(HOLD_CYC - 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("lpm_rst_qual: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic pin_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = rst_pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) sh <= '0;
            else begin
               sh[0] <= rst_pin;
               for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign pin_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   logic [HW-1:0] hi_cnt;
   logic          rst_q;

   assign rst_seen = tick & pin_s;
   assign rst_drop = tick & ~pin_s;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hi_cnt <= '0;
         rst_q  <= 1'b0;
      end else if (rst_seen) begin
         if (hi_cnt != HOLD_MAX) hi_cnt <= hi_cnt + 1'b1;
         if (hi_cnt >= HOLD_PRE) rst_q <= 1'b1;
      end else if (rst_drop) begin
         hi_cnt <= '0;
         rst_q  <= 1'b0;
      end
   end

   assign int_rst = rst_q;

   // R1: reset rises only on a high sample
   p_rst_rise_r1: assert property (@(posedge clk) disable iff (!por_n)
      $rose(int_rst) |-> $past(rst_seen));
   // R2: reset falls only on a low sample
   p_rst_fall_r2: assert property (@(posedge clk) disable iff (!por_n)
      $fell(int_rst) |-> $past(rst_drop));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic      clk,
   input  logic      por_n,
   input  logic      int_rst,
   input  logic      rst_seen,
   input  logic      rst_drop,
   input  logic      mode_we,
   input  logic      mode_idle_set,
   input  logic      mode_pd_set,
   input  logic      irq_pend,
   output pm_state_t state
);
   pm_state_t nxt;

   always_comb begin
      nxt = state;
      if (int_rst) nxt = PM_RUN;
      else begin
         unique case (state)
            PM_RUN: begin
               if (mode_we && mode_pd_set)        nxt = PM_DOWN;
               else if (mode_we && mode_idle_set) nxt = PM_IDLE;
            end
            PM_IDLE: begin
               if (rst_seen)      nxt = PM_WAKE;
               else if (irq_pend) nxt = PM_RUN;
            end
            PM_DOWN: nxt = PM_DOWN;
            PM_WAKE: if (rst_drop) nxt = PM_RUN;
            default: nxt = PM_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) state <= PM_RUN;
      else        state <= nxt;
   end

   // R7: deep sleep holds until qualified reset
   p_pd_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
      (state == PM_DOWN && !int_rst) |=> state == PM_DOWN);
   // R6: interrupt ends light sleep
   p_idle_irq_r6: assert property (@(posedge clk) disable iff (!por_n)
      (state == PM_IDLE && irq_pend && !rst_seen && !int_rst) |=> state == PM_RUN);
   // R8: reset wake-up is only entered from light sleep
   p_wake_entry_r8: assert property (@(posedge clk) disable iff (!por_n)
      (state == PM_WAKE && $past(state) != PM_WAKE) |-> $past(state) == PM_IDLE);
   // R11: qualified reset always lands in running
   p_reset_run_r11: assert property (@(posedge clk) disable iff (!por_n)
      int_rst |=> state == PM_RUN);
endmodule

// File: rtl/lpm_pin_force.sv
module lpm_pin_force
   import lpm_pkg::*;
(
   input  pm_state_t state,
   input  logic      ext_code,
   output logic      pin_hold,
   output logic      ale_lvl,
   output logic      psen_lvl,
   output logic      p0_float,
   output logic      p2_addr
);
   logic light, deep;

   assign light    = (state == PM_IDLE);
   assign deep     = (state == PM_DOWN);
   assign pin_hold = light | deep;
   assign ale_lvl  = light;
   assign psen_lvl = light;
   assign p0_float = pin_hold & ext_code;
   assign p2_addr  = light & ext_code;
endmodule

// File: rtl/lpm_rst_ctrl.sv
module lpm_rst_ctrl
   import lpm_pkg::*;
#(
   parameter int CYC_LEN     = 12,
   parameter int HOLD_CYC    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_pin,
   input  logic mode_we,
   input  logic mode_idle_set,
   input  logic mode_pd_set,
   input  logic irq_pend,
   input  logic ext_code,
   output logic mcyc_tick,
   output logic int_rst,
   output logic cpu_clk_en,
   output logic per_clk_en,
   output logic osc_stop,
   output logic ram_wr_block,
   output logic mode_idle,
   output logic mode_pd,
   output logic pin_hold,
   output logic ale_lvl,
   output logic psen_lvl,
   output logic p0_float,
   output logic p2_addr
);
   logic      rst_seen, rst_drop;
   pm_state_t state;

   lpm_cycle_tick #(.CYC_LEN(CYC_LEN)) u_tick (
      .clk(clk), .por_n(por_n), .tick(mcyc_tick));

   lpm_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) u_qual (
      .clk(clk), .por_n(por_n), .tick(mcyc_tick), .rst_pin(rst_pin),
      .rst_seen(rst_seen), .rst_drop(rst_drop), .int_rst(int_rst));

   lpm_mode_fsm u_fsm (
      .clk(clk), .por_n(por_n), .int_rst(int_rst), .rst_seen(rst_seen),
      .rst_drop(rst_drop), .mode_we(mode_we), .mode_idle_set(mode_idle_set),
      .mode_pd_set(mode_pd_set), .irq_pend(irq_pend), .state(state));

   lpm_pin_force u_pins (
      .state(state), .ext_code(ext_code), .pin_hold(pin_hold),
      .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .p0_float(p0_float),
      .p2_addr(p2_addr));

   assign cpu_clk_en   = (state == PM_RUN) || (state == PM_WAKE);
   assign per_clk_en   = (state != PM_DOWN);
   assign osc_stop     = (state == PM_DOWN);
   assign ram_wr_block = (state == PM_WAKE);
   assign mode_idle    = (state == PM_IDLE) || (state == PM_WAKE);
   assign mode_pd      = (state == PM_DOWN);

   // R9: pins are only forced while the processor is stopped
   p_sleep_pins_r9: assert property (@(posedge clk) disable iff (!por_n)
      pin_hold |-> !cpu_clk_en);
   // R7: oscillator stop implies both clocks are gated
   p_pd_clocks_r7: assert property (@(posedge clk) disable iff (!por_n)
      osc_stop |-> (!per_clk_en && !cpu_clk_en));
endmodule

// File: tb/lpm_rst_ctrl_test.sv
`timescale 1ns/1ps
module lpm_rst_ctrl_test;
   logic clk = 1'b0, por_n = 1'b0, rst_pin = 1'b0;
   logic mode_we = 1'b0, mode_idle_set = 1'b0, mode_pd_set = 1'b0;
   logic irq_pend = 1'b0, ext_code = 1'b0;
   logic mcyc_tick, int_rst, cpu_clk_en, per_clk_en, osc_stop, ram_wr_block;
   logic mode_idle, mode_pd, pin_hold, ale_lvl, psen_lvl, p0_float, p2_addr;
   int   errors = 0, checks = 0;
   logic watch = 1'b0, saw_rst = 1'b0;

   always #2.5 clk = ~clk;

   lpm_rst_ctrl uut (.*);

   always @(posedge clk) if (watch && int_rst) saw_rst <= 1'b1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clk_n(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_mode(input logic idl, input logic pd);
      mode_we = 1'b1; mode_idle_set = idl; mode_pd_set = pd;
      clk_n(1);
      mode_we = 1'b0; mode_idle_set = 1'b0; mode_pd_set = 1'b0;
   endtask

   task automatic t_reset_state;
      chk("R5 run cpu clk", cpu_clk_en, 1);
      chk("R1 int_rst low", int_rst, 0);
      chk("R9 no pin hold", pin_hold, 0);
      chk("R7 osc running", osc_stop, 0);
   endtask

   task automatic t_tick;
      int gap;
      while (!mcyc_tick) clk_n(1);
      clk_n(1);
      chk("R3 tick single", mcyc_tick, 0);
      gap = 1;
      while (!mcyc_tick) begin clk_n(1); gap++; end
      chk("R3 tick period", gap, 12);
   endtask

   task automatic t_idle_internal;
      ext_code = 1'b0;
      wr_mode(1'b1, 1'b0);
      chk("R4 idle entered", mode_idle, 1);
      chk("R5 cpu gated", cpu_clk_en, 0);
      chk("R5 periph on", per_clk_en, 1);
      chk("R9 ale high", ale_lvl, 1);
      chk("R9 psen high", psen_lvl, 1);
      chk("R10 p0 latched", p0_float, 0);
      chk("R10 p2 latched", p2_addr, 0);
      irq_pend = 1'b1;
      clk_n(1);
      irq_pend = 1'b0;
      chk("R6 irq exit", mode_idle, 0);
      chk("R6 cpu back", cpu_clk_en, 1);
   endtask

   task automatic t_idle_external;
      ext_code = 1'b1;
      wr_mode(1'b1, 1'b0);
      chk("R10 p0 float idle", p0_float, 1);
      chk("R10 p2 addr idle", p2_addr, 1);
      wr_mode(1'b0, 1'b1);
      chk("R11 write in idle ignored", mode_pd, 0);
      chk("R11 still idle", mode_idle, 1);
      irq_pend = 1'b1; clk_n(1); irq_pend = 1'b0;
      chk("R6 irq exit ext", pin_hold, 0);
   endtask

   task automatic t_power_down;
      ext_code = 1'b1;
      wr_mode(1'b1, 1'b1);
      chk("R4 both bits pick pd", mode_pd, 1);
      chk("R4 not idle", mode_idle, 0);
      chk("R7 osc stop", osc_stop, 1);
      chk("R7 periph off", per_clk_en, 0);
      chk("R9 ale low", ale_lvl, 0);
      chk("R9 psen low", psen_lvl, 0);
      chk("R10 p0 float pd", p0_float, 1);
      chk("R10 p2 latch pd", p2_addr, 0);
      irq_pend = 1'b1; clk_n(30); irq_pend = 1'b0;
      chk("R7 irq ignored", mode_pd, 1);
      rst_pin = 1'b1;
      clk_n(40);
      chk("R7 reset ends pd", mode_pd, 0);
      chk("R7 int_rst high", int_rst, 1);
      wr_mode(1'b1, 1'b0);
      chk("R11 write under reset ignored", mode_idle, 0);
      rst_pin = 1'b0;
      clk_n(14);
      chk("R2 reset released", int_rst, 0);
      ext_code = 1'b0;
   endtask

   task automatic t_rst_qual;
      rst_pin = 1'b1;
      clk_n(14);
      chk("R1 one tick not enough", int_rst, 0);
      clk_n(24);
      chk("R1 two ticks assert", int_rst, 1);
      rst_pin = 1'b0;
      clk_n(14);
      chk("R2 falls on low sample", int_rst, 0);
      saw_rst = 1'b0; watch = 1'b1;
      rst_pin = 1'b1; clk_n(14); rst_pin = 1'b0;
      clk_n(40);
      watch = 1'b0;
      chk("R1 short pulse ignored", saw_rst, 0);
   endtask

   task automatic t_wake_reset;
      wr_mode(1'b1, 1'b0);
      rst_pin = 1'b1;
      clk_n(14);
      chk("R8 ram blocked", ram_wr_block, 1);
      chk("R8 cpu restarted", cpu_clk_en, 1);
      chk("R8 idle bit kept", mode_idle, 1);
      chk("R8 not yet reset", int_rst, 0);
      clk_n(24);
      chk("R8 reset took over", int_rst, 1);
      chk("R8 block released", ram_wr_block, 0);
      chk("R8 idle bit cleared", mode_idle, 0);
      rst_pin = 1'b0;
      clk_n(14);
   endtask

   task automatic t_wake_drop;
      wr_mode(1'b1, 1'b0);
      rst_pin = 1'b1;
      clk_n(14);
      rst_pin = 1'b0;
      chk("R8 wake entered", ram_wr_block, 1);
      wr_mode(1'b0, 1'b1);
      chk("R11 write in wake ignored", mode_pd, 0);
      clk_n(14);
      chk("R8 drop releases block", ram_wr_block, 0);
      chk("R8 drop clears idle", mode_idle, 0);
      chk("R8 no reset", int_rst, 0);
   endtask

   task automatic t_coincide;
      wr_mode(1'b1, 1'b0);
      while (!mcyc_tick) clk_n(1);
      clk_n(10);
      rst_pin = 1'b1;
      clk_n(2);
      irq_pend = 1'b1;
      clk_n(1);
      irq_pend = 1'b0;
      chk("R12 reset wins block", ram_wr_block, 1);
      chk("R12 reset wins idle bit", mode_idle, 1);
      clk_n(30);
      rst_pin = 1'b0;
      clk_n(14);
      chk("R12 back to run", mode_idle, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      clk_n(2);
      t_reset_state;
      t_tick;
      t_idle_internal;
      t_idle_external;
      t_power_down;
      t_rst_qual;
      t_wake_reset;
      t_wake_drop;
      t_coincide;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule